// File: doc/BRIEF.md
# Macro Engine Execute Unit

This unit is the single-cycle execute stage of a small command-processing macro engine. Each issued instruction word comes with the two source register values already read by the sequencer. The unit works out one 32-bit result. It supports two-operand arithmetic and logic, an add of a signed immediate, and three bitfield forms: one that merges a field into another word and two that pull out a field and shift it. A register-read form drives an address to an external engine register port. The data that port returns in the same cycle becomes the result.

The result, a valid strobe and an unsupported-encoding flag are registered, so they appear one clock after the issue. The register file, write-back routing, branching and carry-chain arithmetic belong to the neighbouring blocks. Encodings that this unit cannot execute raise the flag and give a zero result.

Top module: `macro_exec_unit`

## Requirements
- R1: While reset is held and after it is released, resValid, resData and resInvalid are all 0 until the first issue.
- R2: With instrWord[2:0]=0, the function in instrWord[21:17] selects A+B (0), A−B (2), A^B (8), A|B (9), A&B (10), A&~B (11) or ~(A&B) (12). All arithmetic wraps modulo 2^32.
- R3: With instrWord[2:0]=0, function codes 1, 3 and 4 through 7, and any code above 12, set resInvalid and give resData 0. Operation 6 does the same.
- R4: Operation 1 gives A plus instrWord[31:14], read as an 18-bit two's-complement value and sign-extended.
- R5: The bitfield fields are source position p=instrWord[21:17], size s=instrWord[26:22] and destination position d=instrWord[31:27], with mask m=(1<<s)−1. Operation 2 gives (A & ~(m<<d)) | (((B>>p)&m)<<d).
- R6: Operation 3 gives ((B >> A[4:0]) & m) << d.
- R7: Operation 4 gives ((B >> p) & m) << A[4:0].
- R8: For operation 5, regRdEn is high in the issue cycle and regRdAddr equals A plus the sign-extended immediate. The result is the regRdData value present in that cycle.
- R9: A field size of 0 gives an all-zero mask. Operations 3 and 4 then give 0 and operation 2 gives A unchanged. Register-sourced shift amounts use only A[4:0].
- R10: The result, resValid and resInvalid appear on the clock edge that ends the issue cycle. When issueValid is low, resValid is 0 on the next cycle and resData and resInvalid keep their values.
- R11: regRdEn is high only in a cycle that issues operation 5.
- R12: Operation 7 gives resData 0 with resInvalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An instruction is issued this cycle |
| instrWord | input | 32 | Instruction word |
| srcAVal | input | 32 | Source A register value |
| srcBVal | input | 32 | Source B register value |
| regRdEn | output | 1 | Engine register read request |
| regRdAddr | output | 32 | Engine register read address |
| regRdData | input | 32 | Engine register read data, same cycle |
| resValid | output | 1 | Result valid |
| resData | output | 32 | Result |
| resInvalid | output | 1 | Issued encoding is unsupported |

## Verification
The bench aims at corner cases a careless implementation would get wrong:
- A negative immediate. If it were not sign-extended, add-immediate and read addresses would come out about 2^18 too high.
- A field size of 0. If the mask were built as a plain shift, that case would extract garbage or wipe the destination word.
- A source A whose upper bits are set and is used as a shift amount. If all of A were used, the shift would overshift to zero.
- The carry and borrow codes and the invalid function codes. These must raise the flag, not fall through to add or subtract.

Idle cycles check that the result holds and that no read request leaks out.

// File: rtl/macro_exec_pkg.sv
package macro_exec_pkg;

  localparam int WORD_W  = 32;
  localparam int SHAMT_W = $clog2(WORD_W);
  localparam int IMM_W   = 18;

  localparam logic [2:0] OP_ALU    = 3'd0;
  localparam logic [2:0] OP_ADDI   = 3'd1;
  localparam logic [2:0] OP_INSERT = 3'd2;
  localparam logic [2:0] OP_EXTI   = 3'd3;
  localparam logic [2:0] OP_EXTR   = 3'd4;
  localparam logic [2:0] OP_READ   = 3'd5;
  localparam logic [2:0] OP_RSVD   = 3'd6;
  localparam logic [2:0] OP_BRANCH = 3'd7;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_XOR, FN_OR, FN_AND, FN_ANDN, FN_NAND, FN_NONE
  } aluFn_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ALU, SEL_ADDI, SEL_INSERT, SEL_EXTI, SEL_EXTR, SEL_READ
  } resSel_e;

  typedef struct packed {
    resSel_e resSel;
    aluFn_e  aluFn;
    logic    rdStrobe;
    logic    badStrobe;
  } execStrobes_t;

  typedef struct packed {
    logic [SHAMT_W-1:0] posSrc;
    logic [SHAMT_W-1:0] fieldSize;
    logic [SHAMT_W-1:0] posDst;
    logic [WORD_W-1:0]  immExt;
  } execFields_t;

endpackage

// File: rtl/macro_exec_ctrl.sv
module macro_exec_ctrl
  import macro_exec_pkg::*;
(
  input  logic                issueValid,
  input  logic [WORD_W-1:0]   instrWord,
  output execStrobes_t        strobes,
  output execFields_t         fields
);

  logic [2:0] opCode;
  logic [4:0] fnCode;
  logic       unusedBits;

  assign opCode     = instrWord[2:0];
  assign fnCode     = instrWord[21:17];
  assign unusedBits = ^instrWord[13:3];

  assign fields.posSrc    = instrWord[21:17];
  assign fields.fieldSize = instrWord[26:22];
  assign fields.posDst    = instrWord[31:27];
  assign fields.immExt    = {{(WORD_W-IMM_W){instrWord[31]}}, instrWord[31:WORD_W-IMM_W]};

  always_comb begin
    strobes.resSel    = SEL_ZERO;
    strobes.aluFn     = FN_NONE;
    strobes.rdStrobe  = 1'b0;
    strobes.badStrobe = 1'b0;
    case (opCode)
      OP_ALU: begin
        strobes.resSel = SEL_ALU;
        case (fnCode)
          5'd0:    strobes.aluFn = FN_ADD;
          5'd2:    strobes.aluFn = FN_SUB;
          5'd8:    strobes.aluFn = FN_XOR;
          5'd9:    strobes.aluFn = FN_OR;
          5'd10:   strobes.aluFn = FN_AND;
          5'd11:   strobes.aluFn = FN_ANDN;
          5'd12:   strobes.aluFn = FN_NAND;
          default: begin
            strobes.aluFn     = FN_NONE;
            strobes.resSel    = SEL_ZERO;
            strobes.badStrobe = 1'b1;
          end
        endcase
      end
      OP_ADDI:   strobes.resSel = SEL_ADDI;
      OP_INSERT: strobes.resSel = SEL_INSERT;
      OP_EXTI:   strobes.resSel = SEL_EXTI;
      OP_EXTR:   strobes.resSel = SEL_EXTR;
      OP_READ: begin
        strobes.resSel   = SEL_READ;
        strobes.rdStrobe = issueValid;
      end
      OP_RSVD:   strobes.badStrobe = 1'b1;
      default:   strobes.resSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/macro_exec_dp.sv
module macro_exec_dp
  import macro_exec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  execStrobes_t        strobes,
  input  execFields_t         fields,
  input  logic [WORD_W-1:0]   srcAVal,
  input  logic [WORD_W-1:0]   srcBVal,
  input  logic [WORD_W-1:0]   regRdData,
  output logic                regRdEn,
  output logic [WORD_W-1:0]   regRdAddr,
  output logic                resValid,
  output logic [WORD_W-1:0]   resData,
  output logic                resInvalid
);

  logic [WORD_W-1:0]  fieldMask;
  logic [WORD_W-1:0]  aluOut;
  logic [WORD_W-1:0]  addImmOut;
  logic [WORD_W-1:0]  insertOut;
  logic [WORD_W-1:0]  extImmOut;
  logic [WORD_W-1:0]  extRegOut;
  logic [WORD_W-1:0]  nextRes;
  logic [SHAMT_W-1:0] regShamt;

  // Mask bit i is set when i lies below the field size.
  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign fieldMask[i] = (SHAMT_W'(i) < fields.fieldSize);
  end

  assign regShamt  = srcAVal[SHAMT_W-1:0];
  assign addImmOut = srcAVal + fields.immExt;
  assign regRdAddr = addImmOut;
  assign regRdEn   = strobes.rdStrobe;

  always_comb begin
    case (strobes.aluFn)
      FN_ADD:  aluOut = srcAVal + srcBVal;
      FN_SUB:  aluOut = srcAVal - srcBVal;
      FN_XOR:  aluOut = srcAVal ^ srcBVal;
      FN_OR:   aluOut = srcAVal | srcBVal;
      FN_AND:  aluOut = srcAVal & srcBVal;
      FN_ANDN: aluOut = srcAVal & ~srcBVal;
      FN_NAND: aluOut = ~(srcAVal & srcBVal);
      default: aluOut = '0;
    endcase
  end

  always_comb begin
    logic [WORD_W-1:0] pickedSrc;
    pickedSrc = (srcBVal >> fields.posSrc) & fieldMask;
    insertOut = (srcAVal & ~(fieldMask << fields.posDst)) | (pickedSrc << fields.posDst);
    extRegOut = pickedSrc << regShamt;
    extImmOut = ((srcBVal >> regShamt) & fieldMask) << fields.posDst;
  end

  always_comb begin
    case (strobes.resSel)
      SEL_ALU:    nextRes = aluOut;
      SEL_ADDI:   nextRes = addImmOut;
      SEL_INSERT: nextRes = insertOut;
      SEL_EXTI:   nextRes = extImmOut;
      SEL_EXTR:   nextRes = extRegOut;
      SEL_READ:   nextRes = regRdData;
      default:    nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid   <= 1'b0;
      resData    <= '0;
      resInvalid <= 1'b0;
    end else begin
      resValid <= issueValid;
      if (issueValid) begin
        resData    <= nextRes;
        resInvalid <= strobes.badStrobe;
      end
    end
  end

endmodule

// File: rtl/macro_exec_unit.sv
module macro_exec_unit
  import macro_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [31:0]       instrWord,
  input  logic [31:0]       srcAVal,
  input  logic [31:0]       srcBVal,
  output logic              regRdEn,
  output logic [31:0]       regRdAddr,
  input  logic [31:0]       regRdData,
  output logic              resValid,
  output logic [31:0]       resData,
  output logic              resInvalid
);

  execStrobes_t strobes;
  execFields_t  fields;

  macro_exec_ctrl u_ctrl (
    .issueValid (issueValid),
    .instrWord  (instrWord),
    .strobes    (strobes),
    .fields     (fields)
  );

  macro_exec_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .issueValid (issueValid),
    .strobes    (strobes),
    .fields     (fields),
    .srcAVal    (srcAVal),
    .srcBVal    (srcBVal),
    .regRdData  (regRdData),
    .regRdEn    (regRdEn),
    .regRdAddr  (regRdAddr),
    .resValid   (resValid),
    .resData    (resData),
    .resInvalid (resInvalid)
  );

endmodule

// File: rtl/macro_exec_chk.sv
module macro_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issueValid,
  input logic [31:0] instrWord,
  input logic        regRdEn,
  input logic [31:0] regRdData,
  input logic        resValid,
  input logic [31:0] resData,
  input logic        resInvalid
);

  assert_valid_follows_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> resValid == $past(issueValid));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |=> ($stable(resData) && $stable(resInvalid)));

  assert_read_only_on_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
    regRdEn |-> (issueValid && instrWord[2:0] == 3'd5));

  assert_read_returns_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && instrWord[2:0] == 3'd5) |=> resData == $past(regRdData));

  assert_reserved_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && instrWord[2:0] == 3'd6) |=> resInvalid);

  assert_flag_zero_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resInvalid |-> resData == 32'd0);

endmodule

bind macro_exec_unit macro_exec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issueValid (issueValid),
  .instrWord  (instrWord),
  .regRdEn    (regRdEn),
  .regRdData  (regRdData),
  .resValid   (resValid),
  .resData    (resData),
  .resInvalid (resInvalid)
);

// File: tb/tb_macro_exec_unit.sv
`timescale 1ns/1ps
module tb_macro_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] srcAVal = '0;
  logic [31:0] srcBVal = '0;
  logic        regRdEn;
  logic [31:0] regRdAddr;
  logic [31:0] regRdData;
  logic        resValid;
  logic [31:0] resData;
  logic        resInvalid;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // Model of the external engine register space.
  assign regRdData = {regRdAddr[15:0], ~regRdAddr[15:0]} ^ 32'hC3A5_0F96;

  macro_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .instrWord(instrWord),
    .srcAVal(srcAVal), .srcBVal(srcBVal), .regRdEn(regRdEn), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .resValid(resValid), .resData(resData), .resInvalid(resInvalid)
  );

  function automatic logic [31:0] sext18(logic [31:0] w);
    return {{14{w[31]}}, w[31:14]};
  endfunction

  function automatic logic [31:0] maskOf(logic [4:0] s);
    return (s == 5'd0) ? 32'd0 : ((32'd1 << s) - 32'd1);
  endfunction

  function automatic logic [32:0] model(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [31:0] m, r;
    logic bad;
    logic [4:0] p, d, sa;
    p = w[21:17]; d = w[31:27]; sa = a[4:0];
    m = maskOf(w[26:22]);
    bad = 1'b0; r = 32'd0;
    case (w[2:0])
      3'd0: case (w[21:17])
        5'd0:  r = a + b;
        5'd2:  r = a - b;
        5'd8:  r = a ^ b;
        5'd9:  r = a | b;
        5'd10: r = a & b;
        5'd11: r = a & ~b;
        5'd12: r = ~(a & b);
        default: bad = 1'b1;
      endcase
      3'd1: r = a + sext18(w);
      3'd2: r = (a & ~(m << d)) | (((b >> p) & m) << d);
      3'd3: r = ((b >> sa) & m) << d;
      3'd4: r = ((b >> p) & m) << sa;
      3'd5: begin
        logic [31:0] ad;
        ad = a + sext18(w);
        r = {ad[15:0], ~ad[15:0]} ^ 32'hC3A5_0F96;
      end
      3'd6: bad = 1'b1;
      default: r = 32'd0;
    endcase
    return {bad, r};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(string req, logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [32:0] e;
    e = model(w, a, b);
    @(negedge clk);
    issueValid = 1'b1; instrWord = w; srcAVal = a; srcBVal = b;
    #1;
    if (w[2:0] == 3'd5) begin
      check("R8 rdEn", 32'(regRdEn), 32'd1);
      check("R8 rdAddr", regRdAddr, a + sext18(w));
    end else begin
      check("R11 rdEn", 32'(regRdEn), 32'd0);
    end
    @(negedge clk);
    issueValid = 1'b0;
    check({req, " valid R10"}, 32'(resValid), 32'd1);
    check({req, " data"}, resData, e[31:0]);
    check({req, " invalid"}, 32'(resInvalid), 32'(e[32]));
  endtask

  function automatic logic [31:0] aluW(logic [4:0] fn);
    return {10'd0, fn, 17'd0};
  endfunction

  function automatic logic [31:0] bfW(logic [2:0] op, logic [4:0] p, logic [4:0] s, logic [4:0] d);
    return {d, s, p, 14'd0, op};
  endfunction

  function automatic logic [31:0] immW(logic [2:0] op, logic [17:0] imm);
    return {imm, 11'd0, op};
  endfunction

  initial begin
    logic [31:0] held;
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    #5;
    check("R1 valid in reset", 32'(resValid), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(resValid), 32'd0);
    check("R1 data", resData, 32'd0);
    check("R1 invalid", 32'(resInvalid), 32'd0);

    // R2 each supported function
    issue("R2 add", aluW(5'd0), 32'hFFFF_FFFF, 32'd2);
    issue("R2 sub", aluW(5'd2), 32'd3, 32'd5);
    issue("R2 xor", aluW(5'd8), 32'hF0F0_1234, 32'h0FF0_4321);
    issue("R2 or", aluW(5'd9), 32'hA000_0001, 32'h0500_0010);
    issue("R2 and", aluW(5'd10), 32'hFF00_FF00, 32'h0FF0_0FF0);
    issue("R2 andnot", aluW(5'd11), 32'hFF00_FF00, 32'h0FF0_0FF0);
    issue("R2 nand", aluW(5'd12), 32'hFF00_FF00, 32'h0FF0_0FF0);
    // R3 unsupported codes
    issue("R3 adc", aluW(5'd1), 32'd7, 32'd9);
    issue("R3 sbb", aluW(5'd3), 32'd7, 32'd9);
    issue("R3 fn5", aluW(5'd5), 32'd7, 32'd9);
    issue("R3 fn20", aluW(5'd20), 32'd7, 32'd9);
    issue("R3 op6", 32'h0000_0006, 32'd7, 32'd9);
    // R4 immediates
    issue("R4 pos", immW(3'd1, 18'h0_1234), 32'h100, 32'd0);
    issue("R4 neg", immW(3'd1, 18'h3_FFFF), 32'h100, 32'd0);
    issue("R4 min", immW(3'd1, 18'h2_0000), 32'd0, 32'd0);
    // R5 insert
    issue("R5 insert", bfW(3'd2, 5'd4, 5'd8, 5'd16), 32'hFFFF_FFFF, 32'h0000_0AB0);
    issue("R5 insert top", bfW(3'd2, 5'd0, 5'd31, 5'd1), 32'h0000_0001, 32'hFFFF_FFFF);
    // R6 / R7 and R9 low-bit shift amounts
    issue("R6 ext imm-dst", bfW(3'd3, 5'd0, 5'd4, 5'd8), 32'd12, 32'h0000_F000);
    issue("R9 R6 upper A bits", bfW(3'd3, 5'd0, 5'd4, 5'd0), 32'hFFFF_FFEC, 32'h0000_F000);
    issue("R7 ext reg-dst", bfW(3'd4, 5'd8, 5'd8, 5'd0), 32'd4, 32'h00AB_CD00);
    issue("R9 R7 upper A bits", bfW(3'd4, 5'd8, 5'd8, 5'd0), 32'h0000_0124, 32'h00AB_CD00);
    // R9 zero size
    issue("R9 size0 insert", bfW(3'd2, 5'd3, 5'd0, 5'd5), 32'h1234_5678, 32'hFFFF_FFFF);
    issue("R9 size0 ext", bfW(3'd3, 5'd3, 5'd0, 5'd5), 32'd1, 32'hFFFF_FFFF);
    issue("R9 size0 extr", bfW(3'd4, 5'd3, 5'd0, 5'd5), 32'd1, 32'hFFFF_FFFF);
    // R8 reads
    issue("R8 read", immW(3'd5, 18'h0_0040), 32'h0000_1000, 32'd0);
    issue("R8 read neg", immW(3'd5, 18'h3_FFF0), 32'h0000_1000, 32'd0);
    // R12 branch encoding
    issue("R12 op7", 32'h0000_00F7, 32'd5, 32'd6);

    // R10 idle hold
    held = resData;
    repeat (3) begin
      @(negedge clk);
      check("R10 idle valid", 32'(resValid), 32'd0);
      check("R10 idle data", resData, held);
      check("R11 idle rdEn", 32'(regRdEn), 32'd0);
    end

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 3 == 0) w[21:17] = 5'($urandom_range(0, 12));
      issue("R2-R12 random", w, $urandom, $urandom);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule